// File: doc/BRIEF.md
# Card command and response sequencer

This block issues a single command to a memory card and captures the card's reply. Software loads a 6-bit command index and a 32-bit argument. The argument arrives as two independent 16-bit halves. Software then writes a configuration word. The low two bits of that word select the expected response type. Bit 2 asks for a data phase after the response. Bit 10 holds the command back.

A configuration write marks a command as pending. The command goes out once the card clock is running, the hold bit is clear and no other command is in flight. The card-side interface uses a request/acknowledge handshake. With the acknowledge, the card returns a byte count from 0 to 16 and up to 16 response bytes.

The sequencer checks the byte count against the minimum for the selected type. If the count is too short, it flags a response timeout. Otherwise it packs the bytes into a nine-entry FIFO of 16-bit words and either finishes or starts the data phase with a byte budget of block count times block length.

Top module: `cmd_resp_seq`

## Requirements
- R1: The command register keeps the low 6 bits of a write (select 0). `cmd_readback` returns those bits with bit 6 forced to 1.
- R2: A write with select 1 replaces bits 31:16 of the argument. A write with select 2 replaces bits 15:0. Each leaves the other half unchanged.
- R3: A configuration write (select 3) stores bits 13:0 of the data with bits 8 and 9 forced to 0. The fields used are: bits 1:0 response type, bit 2 data enable, bit 10 hold.
- R4: A pending command with hold clear launches on the first clock edge at which `clk_on` is high and no command is in flight. On launch, `card_req` rises carrying the stored index and argument, `fifo_flush` pulses for one cycle and `active` goes high.
- R5: A configuration write with hold (bit 10) set issues no card request.
- R6: Each type has a minimum byte count: type 0 needs none, types 1 and 3 need 4 bytes, type 2 needs 16 bytes. A count below that minimum sets `stat_timeout`, leaves `stat_resp_done` low, starts no data phase, drops `active` and leaves all FIFO words zero.
- R7: An accepted response sets `stat_resp_done`. With data enable set, it pulses `data_start`, loads `byte_count` with `blk_count*blk_len` and keeps `active` high. With data enable clear, it drops `active`.
- R8: Every completed handshake, whether accepted or timed out, pulses `cmd_done` for exactly one cycle.
- R9: On an accepted response, FIFO word k takes byte 2k in bits 7:0 and byte 2k-1 in bits 15:8. Here byte j is `card_bytes[8j+7:8j]`, and any byte at or beyond `card_len` reads as zero. The FIFO is cleared at launch.
- R10: Each `resp_pop` advances the FIFO read position by one. `resp_word` shows the current entry, and reads as zero once nine entries have been popped.
- R11: Only one command is in flight at a time. A configuration write made while a request is outstanding raises no second request. That command launches on the cycle after the outstanding handshake completes.
- R12: A configuration write with hold clear clears both status bits. Any configuration write, or `clk_on` low, drops `active` when no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 command, 1 argument high, 2 argument low, 3 configuration |
| wr_data | input | 16 | Write data |
| clk_on | input | 1 | Card clock running |
| blk_count | input | 16 | Number of blocks for the data phase |
| blk_len | input | 12 | Block length in bytes |
| resp_pop | input | 1 | Advance the response FIFO read position |
| resp_word | output | 16 | Current response FIFO entry |
| cmd_readback | output | 7 | Command index with bit 6 set |
| arg_readback | output | 32 | Stored argument |
| cfg_readback | output | 14 | Stored configuration |
| card_req | output | 1 | Command request to the card side |
| card_cmd | output | 6 | Command index to the card side |
| card_arg | output | 32 | Argument to the card side |
| card_ack | input | 1 | Card response valid, one cycle |
| card_len | input | 5 | Response byte count, 0 to 16 |
| card_bytes | input | 128 | Response bytes, byte j at bits 8j+7:8j |
| stat_timeout | output | 1 | Response too short |
| stat_resp_done | output | 1 | Response accepted |
| cmd_done | output | 1 | Command completion pulse |
| fifo_flush | output | 1 | Data FIFO clear pulse at launch |
| active | output | 1 | Controller active |
| data_start | output | 1 | Data phase start pulse |
| byte_count | output | 28 | Data phase byte budget |

## Verification
The hardest situation to reach is a configuration write that lands while a request is still outstanding. The write must neither raise a second request nor be lost, and the queued command has to launch right after the first handshake completes. The bench holds the card-side acknowledge back, performs the write during that window, and then confirms that `card_req` stays a single level until the acknowledge. It also confirms that the request rises again on the cycle after completion. Odd byte counts near each type's minimum are also driven, to expose the masking of stale bytes in the cross-word packing.

// File: rtl/cmd_resp_seq.sv
module cmd_resp_seq (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [15:0]  wr_data,
  input  logic         clk_on,
  input  logic [15:0]  blk_count,
  input  logic [11:0]  blk_len,
  input  logic         resp_pop,
  output logic [15:0]  resp_word,
  output logic [6:0]   cmd_readback,
  output logic [31:0]  arg_readback,
  output logic [13:0]  cfg_readback,
  output logic         card_req,
  output logic [5:0]   card_cmd,
  output logic [31:0]  card_arg,
  input  logic         card_ack,
  input  logic [4:0]   card_len,
  input  logic [127:0] card_bytes,
  output logic         stat_timeout,
  output logic         stat_resp_done,
  output logic         cmd_done,
  output logic         fifo_flush,
  output logic         active,
  output logic         data_start,
  output logic [27:0]  byte_count
);
  localparam int          NWORDS   = 9;
  localparam logic [2:0]  SEL_CMD  = 3'd0;
  localparam logic [2:0]  SEL_ARGH = 3'd1;
  localparam logic [2:0]  SEL_ARGL = 3'd2;
  localparam logic [2:0]  SEL_CFG  = 3'd3;
  localparam logic [13:0] CFG_KEEP = 14'h3CFF;
  localparam int          HOLD_BIT = 10;
  localparam int          DATA_BIT = 2;

  logic [5:0]  cmd_q;
  logic [31:0] arg_q;
  logic [13:0] cfg_q;
  logic        pending;
  logic [3:0]  rd_ptr;
  logic [15:0] resp_q [NWORDS];
  logic [15:0] pack_w [NWORDS];
  logic [4:0]  need_len;
  logic        launch;

  assign cmd_readback = {1'b1, cmd_q};
  assign arg_readback = arg_q;
  assign cfg_readback = cfg_q;
  assign card_cmd     = cmd_q;
  assign card_arg     = arg_q;
  assign launch       = pending && clk_on && !cfg_q[HOLD_BIT] && !card_req;
  assign resp_word    = (rd_ptr < 4'(NWORDS)) ? resp_q[rd_ptr] : 16'h0;
  assign need_len     = (cfg_q[1:0] == 2'd0) ? 5'd0 :
                        (cfg_q[1:0] == 2'd2) ? 5'd16 : 5'd4;

  always_comb begin
    for (int k = 0; k < NWORDS; k++) pack_w[k] = 16'h0;
    for (int k = 0; k < NWORDS - 1; k++)
      if (2 * k < int'(card_len)) pack_w[k][7:0] = card_bytes[16*k +: 8];
    for (int k = 1; k < NWORDS; k++)
      if (2 * k - 1 < int'(card_len)) pack_w[k][15:8] = card_bytes[16*k-8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; arg_q <= '0; cfg_q <= '0; pending <= 1'b0;
      rd_ptr <= '0; card_req <= 1'b0; stat_timeout <= 1'b0;
      stat_resp_done <= 1'b0; cmd_done <= 1'b0; fifo_flush <= 1'b0;
      active <= 1'b0; data_start <= 1'b0; byte_count <= '0;
      for (int k = 0; k < NWORDS; k++) resp_q[k] <= '0;
    end else begin
      cmd_done   <= 1'b0;
      fifo_flush <= 1'b0;
      data_start <= 1'b0;
      if (resp_pop && rd_ptr < 4'(NWORDS)) rd_ptr <= rd_ptr + 4'd1;
      if (!clk_on && !card_req) active <= 1'b0;
      if (launch) begin
        card_req   <= 1'b1;
        pending    <= 1'b0;
        active     <= 1'b1;
        fifo_flush <= 1'b1;
        rd_ptr     <= '0;
        for (int k = 0; k < NWORDS; k++) resp_q[k] <= '0;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_CMD:  cmd_q <= wr_data[5:0];
          SEL_ARGH: arg_q[31:16] <= wr_data;
          SEL_ARGL: arg_q[15:0] <= wr_data;
          SEL_CFG: begin
            cfg_q   <= wr_data[13:0] & CFG_KEEP;
            pending <= 1'b1;
            if (!card_req && !launch) active <= 1'b0;
            if (!wr_data[HOLD_BIT]) begin
              stat_timeout   <= 1'b0;
              stat_resp_done <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (card_req && card_ack) begin
        card_req <= 1'b0;
        cmd_done <= 1'b1;
        if (card_len < need_len) begin
          stat_timeout <= 1'b1;
          active       <= 1'b0;
        end else begin
          stat_resp_done <= 1'b1;
          for (int k = 0; k < NWORDS; k++) resp_q[k] <= pack_w[k];
          if (cfg_q[DATA_BIT]) begin
            data_start <= 1'b1;
            byte_count <= blk_count * blk_len;
          end else begin
            active <= 1'b0;
          end
        end
      end
    end
  end

  assert_launch_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_req) |-> fifo_flush && active);
  assert_tout_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_timeout && stat_resp_done));
  assert_data_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> active && stat_resp_done && !card_req);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  assert_rdptr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= 4'(NWORDS));
  assert_single_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    card_req && !card_ack |=> card_req && $stable(cmd_done));
endmodule

// File: tb/cmd_resp_seq_tb.sv
module cmd_resp_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = '0;
  logic [15:0]  wr_data = '0;
  logic         clk_on = 1'b1;
  logic [15:0]  blk_count = '0;
  logic [11:0]  blk_len = '0;
  logic         resp_pop = 1'b0;
  logic [15:0]  resp_word;
  logic [6:0]   cmd_readback;
  logic [31:0]  arg_readback;
  logic [13:0]  cfg_readback;
  logic         card_req;
  logic [5:0]   card_cmd;
  logic [31:0]  card_arg;
  logic         card_ack = 1'b0;
  logic [4:0]   card_len = '0;
  logic [127:0] card_bytes = '0;
  logic         stat_timeout, stat_resp_done, cmd_done, fifo_flush, active, data_start;
  logic [27:0]  byte_count;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmd_resp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clk_on(clk_on), .blk_count(blk_count), .blk_len(blk_len), .resp_pop(resp_pop),
    .resp_word(resp_word), .cmd_readback(cmd_readback), .arg_readback(arg_readback),
    .cfg_readback(cfg_readback), .card_req(card_req), .card_cmd(card_cmd),
    .card_arg(card_arg), .card_ack(card_ack), .card_len(card_len),
    .card_bytes(card_bytes), .stat_timeout(stat_timeout),
    .stat_resp_done(stat_resp_done), .cmd_done(cmd_done), .fifo_flush(fifo_flush),
    .active(active), .data_start(data_start), .byte_count(byte_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic respond(input logic [4:0] len, input logic [127:0] b);
    int n = 0;
    while (!card_req && n < 20) begin @(negedge clk); n++; end
    card_ack = 1'b1; card_len = len; card_bytes = b;
    @(negedge clk);
    card_ack = 1'b0;
  endtask

  function automatic logic [127:0] mk_bytes(input logic [7:0] base);
    logic [127:0] r = '0;
    for (int j = 0; j < 16; j++) r[8*j +: 8] = base + 8'(j);
    return r;
  endfunction

  function automatic logic [15:0] exp_word(input int k, input int len, input logic [127:0] b);
    logic [15:0] w = '0;
    if (k < 8 && 2 * k < len) w[7:0] = b[16*k +: 8];
    if (k >= 1 && 2 * k - 1 < len) w[15:8] = b[16*k-8 +: 8];
    return w;
  endfunction

  task automatic check_fifo(input string req, input int len, input logic [127:0] b, input bit zero);
    for (int k = 0; k < 9; k++) begin
      chk(req, 32'(resp_word), zero ? 32'h0 : 32'(exp_word(k, len, b)));
      resp_pop = 1'b1;
      @(negedge clk);
      resp_pop = 1'b0;
    end
    chk("R10 past ninth", 32'(resp_word), 32'h0);
  endtask

  task automatic t_reset();
    chk("R4 reset req", 32'(card_req), 0);
    chk("R6 reset status", {stat_timeout, stat_resp_done}, 0);
    chk("R1 reset readback", 32'(cmd_readback), 32'h40);
    chk("R10 reset word", 32'(resp_word), 0);
  endtask

  task automatic t_regs();
    wr(3'd0, 16'hFFFF);
    chk("R1 cmd mask", 32'(cmd_readback), 32'h7F);
    wr(3'd1, 16'h1234); wr(3'd2, 16'hABCD);
    chk("R2 arg", arg_readback, 32'h1234ABCD);
    wr(3'd1, 16'h5555);
    chk("R2 high only", arg_readback, 32'h5555ABCD);
    wr(3'd3, 16'hFFFF);
    chk("R3 cfg keep", 32'(cfg_readback), 32'h3CFF);
    repeat (3) @(negedge clk);
    chk("R5 hold no req", 32'(card_req), 0);
  endtask

  task automatic t_short();
    logic [127:0] b = mk_bytes(8'h30);
    wr(3'd0, 16'd17); wr(3'd3, 16'h0001);
    @(negedge clk);
    chk("R4 req", 32'(card_req), 1);
    chk("R4 cmd", 32'(card_cmd), 17);
    chk("R4 arg", card_arg, 32'h5555ABCD);
    chk("R4 flush", 32'(fifo_flush), 1);
    chk("R4 active", 32'(active), 1);
    respond(5'd3, b);
    chk("R8 done on timeout", 32'(cmd_done), 1);
    chk("R6 timeout", {stat_timeout, stat_resp_done}, 32'h2);
    chk("R6 inactive", 32'(active), 0);
    chk("R6 no data", 32'(data_start), 0);
    @(negedge clk);
    chk("R8 single pulse", 32'(cmd_done), 0);
    check_fifo("R6 fifo zero", 3, b, 1'b1);
  endtask

  task automatic t_long();
    logic [127:0] b = mk_bytes(8'h10);
    wr(3'd3, 16'h0002);
    respond(5'd16, b);
    chk("R8 done", 32'(cmd_done), 1);
    chk("R7 resp ok", {stat_timeout, stat_resp_done}, 32'h1);
    chk("R7 no data inactive", 32'(active), 0);
    check_fifo("R9 pack 16", 16, b, 1'b0);
    wr(3'd3, 16'h0002);
    respond(5'd15, b);
    chk("R6 type2 short", {stat_timeout, stat_resp_done}, 32'h2);
  endtask

  task automatic t_odd();
    logic [127:0] b = mk_bytes(8'hA0);
    wr(3'd3, 16'h0003);
    respond(5'd5, b);
    chk("R7 type3 ok", {stat_timeout, stat_resp_done}, 32'h1);
    check_fifo("R9 pack odd", 5, b, 1'b0);
  endtask

  task automatic t_data();
    blk_count = 16'd3; blk_len = 12'd512;
    wr(3'd3, 16'h0005);
    respond(5'd4, mk_bytes(8'h00));
    chk("R7 data start", 32'(data_start), 1);
    chk("R7 byte count", 32'(byte_count), 1536);
    chk("R7 active kept", 32'(active), 1);
    @(negedge clk);
    chk("R7 start pulse", 32'(data_start), 0);
    wr(3'd3, 16'h0405);
    chk("R12 cancel", 32'(active), 0);
    chk("R12 hold keeps status", 32'(stat_resp_done), 1);
    wr(3'd3, 16'h0000);
    chk("R12 status cleared", {stat_timeout, stat_resp_done}, 0);
    respond(5'd0, '0);
    chk("R6 type0 none needed", {stat_timeout, stat_resp_done}, 32'h1);
    chk("R7 type0 ends", 32'(active), 0);
  endtask

  task automatic t_clk();
    clk_on = 1'b0;
    wr(3'd3, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R4 wait clock", 32'(card_req), 0);
    clk_on = 1'b1;
    @(negedge clk);
    chk("R4 launch on clock", 32'(card_req), 1);
    chk("R4 flush on clock", 32'(fifo_flush), 1);
    respond(5'd4, mk_bytes(8'h55));
    wr(3'd3, 16'h0005);
    respond(5'd4, mk_bytes(8'h55));
    clk_on = 1'b0;
    @(negedge clk);
    chk("R12 clock off", 32'(active), 0);
    clk_on = 1'b1;
  endtask

  task automatic t_busy();
    wr(3'd0, 16'd9);
    wr(3'd3, 16'h0001);
    @(negedge clk);
    chk("R11 first req", 32'(card_req), 1);
    wr(3'd3, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R11 no second req", 32'(card_req), 1);
    chk("R11 no early done", 32'(cmd_done), 0);
    respond(5'd4, mk_bytes(8'h01));
    chk("R11 first done", 32'(cmd_done), 1);
    chk("R11 req dropped", 32'(card_req), 0);
    @(negedge clk);
    chk("R11 queued launch", 32'(card_req), 1);
    respond(5'd4, mk_bytes(8'h02));
    chk("R11 second done", 32'(cmd_done), 1);
    @(negedge clk);
    chk("R11 idle after", 32'(card_req), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_short();
    t_long();
    t_odd();
    t_data();
    t_clk();
    t_busy();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule